// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between the serial-bus slave engine of a two-wire memory device and its storage array. After the word address of a write transaction has been decoded, the slave engine loads that address here and hands over each data byte once all eight of its bits have arrived. The block keeps those bytes in a 32-entry page buffer. Each buffer entry has a flag that records whether it holds a received byte. The upper address bits select the page and never move during a transaction. Only the 5-bit offset inside the page advances, and it wraps from 31 back to 0.

When the bus reports a stop, the block decides whether to commit. If write protection is active, the supply is reported low, or no complete byte was received, the transaction is dropped. Otherwise the block walks the 32 offsets in ascending order and issues one array write per clock for every flagged entry. It holds a busy flag for a fixed, parameterised number of system clocks, which stands in for the self-timed programming cycle. While busy, it ignores all requests from the slave engine.

Top module: `page_commit_buf`

## Requirements
- R1: A load request takes the page (address bits 12..5) and the starting offset (bits 4..0) from `start_addr` and empties the buffer. Each accepted byte is stored at the current offset, and then the offset advances by one modulo 32. The page bits never change between loads.
- R2: When more than 32 bytes are sent after one load, the offset wraps. Byte 33 replaces the byte buffered at the starting offset, and the array receives only the most recent byte for each offset.
- R3: Array writes happen only after a stop. No write is issued while bytes are being received. Only offsets that received a complete byte are written, at address {page, offset}. Writes run in strictly ascending offset order, at most one per clock, starting in the first cycle after the stop is sampled.
- R4: A stop with no complete byte buffered writes nothing and leaves `busy` low. A stop with `byte_abort` high (a byte cut short) still commits every complete byte received before it.
- R5: If `wp_lvl` is high in the cycle the stop is sampled, no array write occurs and `busy` stays low.
- R6: If `low_vdd` is high in the cycle the stop is sampled, the write is cancelled: no array write occurs and `busy` stays low.
- R7: After an accepted stop, `busy` is high for exactly WRITE_CYCLES clock cycles, beginning in the cycle after the stop is sampled.
- R8: While `busy` is high, load requests, bytes and stops are all ignored. The cycle length, the page written and the set of bytes written are unaffected.
- R9: After a commit ends or a stop is cancelled, the buffer is empty. A following stop without new bytes writes nothing and leaves `busy` low.
- R10: During and right after reset, `busy` and `arr_we` are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_addr | input | 1 | Strobe: take a new start address and empty the buffer |
| start_addr | input | 13 | Word address: page in bits 12..5, offset in bits 4..0 |
| byte_vld | input | 1 | Strobe: one complete data byte received |
| byte_data | input | 8 | Data byte accompanying `byte_vld` |
| byte_abort | input | 1 | Level: the stop cut off a partially received byte |
| stop_strb | input | 1 | Strobe: stop condition seen on the bus |
| wp_lvl | input | 1 | Write-protect level, sampled at the stop |
| low_vdd | input | 1 | Low-supply flag, sampled at the stop |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 13 | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | High during the timed write cycle |

## Verification
The hardest case to reach is a full request sequence (load, byte, stop) arriving while a commit is still running. Such traffic must leave the page being written, the write count and the cycle length unchanged. The bench reaches this case by forking a busy-length monitor alongside a stimulus thread that fires those requests a few cycles into the cycle. It then sends a bare stop to confirm that the buffer was emptied. Wrap-around is exercised with starting offsets near the top of a page and with runs of 33 and 40 bytes.

// File: rtl/pgw_pkg.sv
// Shared types for the page write buffer.
package pgw_pkg;
    // Commit controller state: collecting bytes, or running the timed write.
    typedef enum logic {
        PGW_IDLE = 1'b0,
        PGW_RUN  = 1'b1
    } pgw_state_e;
endpackage

// File: rtl/pgw_page_store.sv
// Page buffer: one register slot per in-page offset, plus a valid mask.
// Assumes the caller never asserts accept together with clear_req, and
// that load_req wins over byte_req in the same cycle.
module pgw_page_store #(
    parameter int DATA_W    = 8,
    parameter int PAGE_BITS = 5,
    parameter int HI_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 load_req,
    input  logic [HI_W-1:0]      load_hi,
    input  logic [PAGE_BITS-1:0] load_off,
    input  logic                 byte_req,
    input  logic [DATA_W-1:0]    byte_in,
    input  logic                 clear_req,
    input  logic [PAGE_BITS-1:0] rd_off,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_vld,
    output logic [HI_W-1:0]      page_hi,
    output logic                 any_valid
);
    localparam int PAGE_SIZE = 1 << PAGE_BITS;

    logic [PAGE_SIZE-1:0]        vmask_q;
    logic [PAGE_BITS-1:0]        wr_off_q;
    logic [HI_W-1:0]             page_q;
    logic [PAGE_SIZE*DATA_W-1:0] slots_flat;
    logic                        take_byte;

    assign take_byte = accept && !load_req && byte_req;

    // Pointer, page and valid-mask update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vmask_q  <= '0;
            wr_off_q <= '0;
            page_q   <= '0;
        end else if (clear_req) begin
            vmask_q <= '0;
        end else if (accept && load_req) begin
            page_q   <= load_hi;
            wr_off_q <= load_off;
            vmask_q  <= '0;
        end else if (take_byte) begin
            vmask_q[wr_off_q] <= 1'b1;
            wr_off_q          <= wr_off_q + 1'b1;
        end
    end

    // One data register per offset.
    for (genvar g = 0; g < PAGE_SIZE; g++) begin : g_slot
        logic [DATA_W-1:0] cell_q;
        // Capture the byte aimed at this offset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= '0;
            else if (take_byte && (wr_off_q == PAGE_BITS'(g)))
                cell_q <= byte_in;
        end
        assign slots_flat[g*DATA_W +: DATA_W] = cell_q;
    end

    assign rd_data   = slots_flat[rd_off*DATA_W +: DATA_W];
    assign rd_vld    = vmask_q[rd_off];
    assign page_hi   = page_q;
    assign any_valid = |vmask_q;

    // R1
    no_page_drift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(accept && load_req)) |=> $stable(page_hi));

    // R9
    mask_empty_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> !any_valid);
endmodule

// File: rtl/pgw_cycle_timer.sv
// Down-counter that models the self-timed write period.
// Assumes CYCLES >= 1; zero is high once the loaded count has run out.
module pgw_cycle_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic zero
);
    localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load at commit start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= LOAD_VAL;
        else if (run && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pgw_commit_ctrl.sv
// Commit controller: decides at a stop whether to launch or cancel, then
// scans the page offsets in ascending order while the timer runs.
// Assumes WRITE_CYCLES >= 2**PAGE_BITS so the scan ends before the cycle does.
module pgw_commit_ctrl
    import pgw_pkg::*;
#(
    parameter int PAGE_BITS = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stop_req,
    input  logic                 wp_lvl,
    input  logic                 low_vdd,
    input  logic                 have_data,
    input  logic                 tmr_zero,
    output logic                 busy,
    output logic                 launch,
    output logic                 cancel,
    output logic                 done,
    output logic                 scan_act,
    output logic [PAGE_BITS-1:0] scan_off
);
    pgw_state_e           state_q;
    logic [PAGE_BITS:0]   scan_q;
    logic                 idle;
    logic                 veto;

    // Launch/cancel decision, taken only in the stop cycle.
    always_comb begin
        idle     = (state_q == PGW_IDLE);
        veto     = wp_lvl || low_vdd || !have_data;
        launch   = idle && stop_req && !veto;
        cancel   = idle && stop_req && veto;
        done     = !idle && tmr_zero;
        busy     = !idle;
        scan_act = !idle && !scan_q[PAGE_BITS];
        scan_off = scan_q[PAGE_BITS-1:0];
    end

    // State and offset-scan register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PGW_IDLE;
            scan_q  <= '0;
        end else begin
            if (launch)
                state_q <= PGW_RUN;
            else if (done)
                state_q <= PGW_IDLE;
            if (launch)
                scan_q <= '0;
            else if (scan_act)
                scan_q <= scan_q + 1'b1;
        end
    end

    // R5
    wp_blocks_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !busy && wp_lvl) |=> !busy);

    // R6
    low_supply_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !busy && low_vdd) |=> !busy);
endmodule

// File: rtl/page_commit_buf.sv
// Top: page write buffer with stop-triggered commit and timed busy window.
// Assumes the slave engine delivers one strobe per cycle at most; when a
// stop and a byte coincide, the stop wins and the byte is dropped.
module page_commit_buf #(
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int PAGE_BITS    = 5,
    parameter int WRITE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              byte_abort,
    input  logic              stop_strb,
    input  logic              wp_lvl,
    input  logic              low_vdd,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              busy
);
    localparam int HI_W      = ADDR_W - PAGE_BITS;
    localparam int PAGE_SIZE = 1 << PAGE_BITS;
    localparam int RUN_W     = $clog2(WRITE_CYCLES + 2);

    logic                 accept;
    logic                 launch, cancel, done, scan_act, tmr_zero;
    logic                 rd_vld, any_valid;
    logic [PAGE_BITS-1:0] scan_off;
    logic [DATA_W-1:0]    rd_data;
    logic [HI_W-1:0]      page_hi;

    assign accept = !busy && !stop_strb;

    pgw_page_store #(
        .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .HI_W(HI_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .load_req(load_addr),
        .load_hi(start_addr[ADDR_W-1:PAGE_BITS]),
        .load_off(start_addr[PAGE_BITS-1:0]),
        .byte_req(byte_vld), .byte_in(byte_data),
        .clear_req(cancel || done),
        .rd_off(scan_off), .rd_data(rd_data), .rd_vld(rd_vld),
        .page_hi(page_hi), .any_valid(any_valid)
    );

    pgw_commit_ctrl #(.PAGE_BITS(PAGE_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_strb),
        .wp_lvl(wp_lvl), .low_vdd(low_vdd), .have_data(any_valid),
        .tmr_zero(tmr_zero), .busy(busy), .launch(launch),
        .cancel(cancel), .done(done), .scan_act(scan_act),
        .scan_off(scan_off)
    );

    pgw_cycle_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(launch), .run(busy),
        .zero(tmr_zero)
    );

    assign arr_we    = scan_act && rd_vld;
    assign arr_addr  = {page_hi, scan_off};
    assign arr_wdata = rd_data;

    // Checker state: length of the current busy run and writes within it.
    logic [RUN_W-1:0]   run_len_q;
    logic [PAGE_BITS+1:0] wr_cnt_q;

    // Track busy length and number of writes for the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            run_len_q <= '0;
            wr_cnt_q  <= '0;
        end else begin
            run_len_q <= run_len_q + 1'b1;
            if (arr_we)
                wr_cnt_q <= wr_cnt_q + 1'b1;
        end
    end

    // R7
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len_q == RUN_W'(WRITE_CYCLES)));

    // R3
    start_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_strb));

    // R3
    write_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R3
    ascending_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
            (arr_addr[PAGE_BITS-1:0] > $past(arr_addr[PAGE_BITS-1:0])));

    // R2
    write_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_q <= (PAGE_BITS+2)'(PAGE_SIZE));

    // R8
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(arr_addr[ADDR_W-1:PAGE_BITS]));

    // R4
    abort_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_strb && byte_abort && !busy && !any_valid) |=> !busy);
endmodule

// File: tb/page_commit_buf_test.sv
module page_commit_buf_test;
    localparam int W  = 40;
    localparam int NV = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_addr = 1'b0, byte_vld = 1'b0, byte_abort = 1'b0;
    logic        stop_strb = 1'b0, wp_lvl = 1'b0, low_vdd = 1'b0;
    logic [12:0] start_addr = '0;
    logic [7:0]  byte_data = '0;
    logic        arr_we, busy;
    logic [12:0] arr_addr;
    logic [7:0]  arr_wdata;

    int checks = 0, errors = 0;
    int wr_cnt = 0, order_bad = 0, last_off = 0;
    bit finished = 0;
    logic [7:0] shadow [int];
    logic [7:0] exp_mem [int];

    page_commit_buf #(.WRITE_CYCLES(W)) uut (
        .clk(clk), .rst_n(rst_n), .load_addr(load_addr),
        .start_addr(start_addr), .byte_vld(byte_vld), .byte_data(byte_data),
        .byte_abort(byte_abort), .stop_strb(stop_strb), .wp_lvl(wp_lvl),
        .low_vdd(low_vdd), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .busy(busy)
    );

    always #5 clk = ~clk;

    // {addr[12:0], count[5:0], wp, low, abort, seed[7:0]}
    localparam logic [29:0] VEC [NV] = '{
        {13'h0100, 6'd1,  1'b0, 1'b0, 1'b0, 8'h3C},
        {13'h1FE5, 6'd10, 1'b0, 1'b0, 1'b0, 8'h11},
        {13'h0A1C, 6'd8,  1'b0, 1'b0, 1'b0, 8'h80},
        {13'h0040, 6'd33, 1'b0, 1'b0, 1'b0, 8'h05},
        {13'h0300, 6'd4,  1'b1, 1'b0, 1'b0, 8'h99},
        {13'h0400, 6'd4,  1'b0, 1'b1, 1'b0, 8'h42},
        {13'h0500, 6'd0,  1'b0, 1'b0, 1'b1, 8'h00},
        {13'h0600, 6'd3,  1'b0, 1'b0, 1'b1, 8'hE7},
        {13'h07FF, 6'd40, 1'b0, 1'b0, 1'b0, 8'h6A},
        {13'h0040, 6'd2,  1'b0, 1'b0, 1'b0, 8'hD2}
    };

    // Array model fed by the write port.
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            shadow[int'(arr_addr)] = arr_wdata;
            if (wr_cnt > 0 && int'(arr_addr[4:0]) <= last_off) order_bad++;
            last_off = int'(arr_addr[4:0]);
            wr_cnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic pulse_load(input logic [12:0] a);
        @(posedge clk); #1 load_addr = 1'b1; start_addr = a;
        @(posedge clk); #1 load_addr = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(posedge clk); #1 byte_vld = 1'b1; byte_data = d;
        @(posedge clk); #1 byte_vld = 1'b0;
    endtask

    task automatic send_stop(input logic wp, input logic lo, input logic ab);
        @(posedge clk); #1 stop_strb = 1'b1; wp_lvl = wp; low_vdd = lo; byte_abort = ab;
        @(posedge clk); #1 stop_strb = 1'b0; wp_lvl = 1'b0; low_vdd = 1'b0; byte_abort = 1'b0;
    endtask

    task automatic busy_len(output int len);
        len = 0;
        @(negedge clk);
        while (busy) begin
            len++;
            @(negedge clk);
        end
    endtask

    function automatic int mem_diff();
        int n = 0;
        foreach (exp_mem[k])
            if (!shadow.exists(k) || shadow[k] !== exp_mem[k]) n++;
        foreach (shadow[k])
            if (!exp_mem.exists(k)) n++;
        return n;
    endfunction

    function automatic string vec_tag(input int n, input logic wp, input logic lo);
        if (wp) return "R5";
        if (lo) return "R6";
        if (n == 0) return "R4";
        if (n > 32) return "R2";
        return "R1";
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int len;
        string tag;
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0 && arr_we == 1'b0, "R10 reset outputs", {busy, arr_we}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        send_stop(0, 0, 0);
        busy_len(len);
        check(len == 0 && wr_cnt == 0, "R10 buffer empty after reset", len + wr_cnt, 0);

        // Table-driven transactions
        for (int v = 0; v < NV; v++) begin
            logic [12:0] a  = VEC[v][29:17];
            int          n  = int'(VEC[v][16:11]);
            logic        wp = VEC[v][10];
            logic        lo = VEC[v][9];
            logic        ab = VEC[v][8];
            logic [7:0]  sd = VEC[v][7:0];
            bit          commit = !wp && !lo && (n != 0);
            tag = vec_tag(n, wp, lo);
            wr_cnt = 0; order_bad = 0;
            pulse_load(a);
            for (int i = 0; i < n; i++) begin
                logic [7:0] d = sd + 8'(i * 29);
                send_byte(d);
                if (commit)
                    exp_mem[int'({a[12:5], 5'(a[4:0] + 5'(i))})] = d;
            end
            repeat (3) @(negedge clk);
            check(wr_cnt == 0 && busy == 1'b0, "R3 no write before stop", wr_cnt, 0);
            send_stop(wp, lo, ab);
            busy_len(len);
            check(len == (commit ? W : 0), {tag, " R7 busy length"}, len, commit ? W : 0);
            check(mem_diff() == 0, {tag, " array contents"}, mem_diff(), 0);
            check(wr_cnt == (commit ? (n > 32 ? 32 : n) : 0), {tag, " R3 write count"},
                  wr_cnt, commit ? (n > 32 ? 32 : n) : 0);
            check(order_bad == 0, "R3 ascending offsets", order_bad, 0);
        end

        // R8: requests during the write cycle are ignored
        wr_cnt = 0;
        pulse_load(13'h0800);
        send_byte(8'hA1);
        send_byte(8'hA2);
        exp_mem[int'(13'h0800)] = 8'hA1;
        exp_mem[int'(13'h0801)] = 8'hA2;
        send_stop(0, 0, 0);
        fork
            busy_len(len);
            begin
                repeat (4) @(posedge clk);
                pulse_load(13'h0900);
                send_byte(8'h55);
                send_stop(0, 0, 0);
            end
        join
        check(len == W, "R8 cycle length unchanged", len, W);
        check(wr_cnt == 2, "R8 write count unchanged", wr_cnt, 2);
        check(mem_diff() == 0, "R8 page and data unchanged", mem_diff(), 0);

        // R9: buffer empty after a commit
        send_stop(0, 0, 0);
        busy_len(len);
        check(len == 0 && wr_cnt == 2, "R9 stop after commit writes nothing", len + wr_cnt, 2);

        // R9: buffer empty after a cancelled stop
        wr_cnt = 0;
        pulse_load(13'h0A00);
        send_byte(8'h77);
        send_stop(0, 1, 0);
        busy_len(len);
        check(len == 0, "R6 cancelled stop leaves busy low", len, 0);
        send_stop(0, 0, 0);
        busy_len(len);
        check(len == 0 && wr_cnt == 0 && mem_diff() == 0,
              "R9 stop after cancel writes nothing", len + wr_cnt, 0);

        finish_run();
    end
endmodule